// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home node of a directory-based coherence scheme for a small distributed shared-memory machine. For every memory block it owns, it keeps a coherence state and a bit-vector with one presence bit per processor. While a block is Exclusive, the single set bit names the owner. A small register array stands in for the home memory that holds the block values.

Requests arrive one at a time over a valid/ready handshake. Each request carries a kind, a requester ID, a block address and, for write-backs, a data word. The controller looks up the entry and updates it. It then emits the point-to-point messages the transition calls for on a single message port, one message per cycle: data replies, invalidates, fetches and fetch/invalidates. When the current owner must surrender the block, the controller stalls further requests until the owner's data arrives on a separate fetch-return input.

Top module: `coh_dir_home`

## Requirements
- R1: After reset, `req_ready` is high, `msg_valid` is low, every block is Uncached with an empty sharer vector, and every memory word reads as zero.
- R2: A read miss (`req_kind`=0) to an Uncached block returns a data reply (`msg_kind`=0) to the requester, carrying the memory word, in the cycle after acceptance. The block becomes Shared with the requester as its only sharer.
- R3: A write miss (`req_kind`=1) to an Uncached block returns a data reply to the requester in the cycle after acceptance. The block becomes Exclusive, owned by the requester.
- R4: A read miss to a Shared block replies with the memory word in the cycle after acceptance and adds the requester to the sharers. The state stays Shared.
- R5: A write miss to a Shared block sends an invalidate (`msg_kind`=1) to every sharer except the requester, one per cycle in ascending ID order, starting the cycle after acceptance. A data reply to the requester follows in the next cycle. If the requester is the only sharer, the reply comes at once. The block becomes Exclusive, owned by the requester.
- R6: A read miss to an Exclusive block sends a fetch (`msg_kind`=2) to the owner in the cycle after acceptance. When `fet_valid` is sampled, the returned word is written to memory and replied to the requester. The block becomes Shared by the old owner and the requester.
- R7: A write miss to an Exclusive block sends a fetch/invalidate (`msg_kind`=3) to the owner. The word returned on `fet_valid` is replied to the requester, which becomes the sole owner.
- R8: A write-back (`req_kind`=2) from the owner of an Exclusive block writes `req_data` to memory, clears the sharers and makes the block Uncached, with no message.
- R9: A write-back from any processor that is not the owner of an Exclusive block has no effect and produces no message. The same holds for any request with `req_kind`=3.
- R10: `req_ready` is low from the acceptance of a request that needs invalidates or a fetch until the cycle after its data reply is issued. Messages of the invalidate and fetch kinds never appear while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | 2 | Requesting processor ID |
| req_addr | input | 4 | Block address |
| req_data | input | 32 | Write-back data |
| fet_valid | input | 1 | Owner data for an outstanding fetch is present |
| fet_data | input | 32 | Owner data |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_kind | output | 2 | 0 reply, 1 invalidate, 2 fetch, 3 fetch/invalidate |
| msg_dst | output | 2 | Destination processor ID |
| msg_addr | output | 4 | Block address of the message |
| msg_data | output | 32 | Reply data |

## Verification
All messages are registered. A reply to a read or write miss that needs no other node is visible right after the clock edge that accepts the request. The k-th invalidate of a write miss appears k edges after acceptance, and the reply one edge after the last invalidate. A fetch appears at the accept edge, and its reply appears at the edge that samples `fet_valid`. Each scenario task drives inputs at the falling edge and samples one time unit after each rising edge, walking those edges one at a time. It checks for no message on cycles that must be silent, so missing, extra or reordered messages are all caught. Directory state is inferred through the ports: a later request shows it by whether it draws a reply, invalidates or a fetch.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {ST_UNC = 2'd0, ST_SHR = 2'd1, ST_EXC = 2'd2} dir_st_e;
  typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_WRITE = 2'd1, RQ_WBACK = 2'd2} req_kind_e;
  typedef enum logic [1:0] {MS_REPLY = 2'd0, MS_INVAL = 2'd1, MS_FETCH = 2'd2, MS_FINV = 2'd3} msg_kind_e;
  typedef enum logic [1:0] {FS_IDLE = 2'd0, FS_INV = 2'd1, FS_WAIT = 2'd2} fsm_e;
endpackage

// File: rtl/coh_dir_pick.sv
// Lowest set bit of a vector, as an index.
module coh_dir_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/coh_dir_table.sv
// Per-block directory entries: state and presence vector.
module coh_dir_table #(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  localparam int AW   = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr,
  output logic [1:0]       rd_st,
  output logic [NPROC-1:0] rd_sh,
  input  logic             we,
  input  logic [AW-1:0]    wr_addr,
  input  logic [1:0]       wr_st,
  input  logic [NPROC-1:0] wr_sh
);
  logic [1:0]       st_q [NBLK];
  logic [NPROC-1:0] sh_q [NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_ent
    logic en;
    assign en = we && (wr_addr == AW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[b] <= 2'd0;
        sh_q[b] <= '0;
      end else if (en) begin
        st_q[b] <= wr_st;
        sh_q[b] <= wr_sh;
      end
    end
  end

  assign rd_st = st_q[rd_addr];
  assign rd_sh = sh_q[rd_addr];
endmodule

// File: rtl/coh_dir_mem.sv
// Home memory model: one word per block.
module coh_dir_mem #(
  parameter int NBLK   = 16,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] word_q [NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          word_q[b] <= '0;
      else if (we && wr_addr == AW'(b))    word_q[b] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_addr];
endmodule

// File: rtl/coh_dir_home.sv
module coh_dir_home
  import coh_dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NBLK   = 16,
  parameter int DATA_W = 32,
  localparam int PID_W = $clog2(NPROC),
  localparam int AW    = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [PID_W-1:0]  req_src,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              fet_valid,
  input  logic [DATA_W-1:0] fet_data,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [PID_W-1:0]  msg_dst,
  output logic [AW-1:0]     msg_addr,
  output logic [DATA_W-1:0] msg_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  fsm_e             fsm_q, fsm_d;
  logic [NPROC-1:0] mask_q, mask_d;
  logic [PID_W-1:0] r_src;
  logic [AW-1:0]    r_addr;
  logic [1:0]       r_kind;

  logic             accept;
  logic [PID_W-1:0] cur_src;
  logic [AW-1:0]    cur_addr;
  logic [NPROC-1:0] src_oh;

  logic [1:0]        ent_st_raw;
  dir_st_e           ent_st;
  logic [NPROC-1:0]  ent_sh;
  logic [DATA_W-1:0] mem_rd;
  logic [PID_W-1:0]  owner, inv_idx;

  logic              t_we, d_we;
  dir_st_e           t_st;
  logic [NPROC-1:0]  t_sh;
  logic [DATA_W-1:0] d_wdata;
  logic              m_v;
  msg_kind_e         m_k;
  logic [PID_W-1:0]  m_dst;
  logic [DATA_W-1:0] m_data;

  assign req_ready = (fsm_q == FS_IDLE) && rst_ni;
  assign accept    = req_valid && req_ready;
  assign cur_src   = (fsm_q == FS_IDLE) ? req_src  : r_src;
  assign cur_addr  = (fsm_q == FS_IDLE) ? req_addr : r_addr;
  assign src_oh    = {{(NPROC-1){1'b0}}, 1'b1} << cur_src;
  assign ent_st    = dir_st_e'(ent_st_raw);

  coh_dir_table #(.NPROC(NPROC), .NBLK(NBLK)) table_i (
    .clk(clk), .rst_n(rst_ni), .rd_addr(cur_addr), .rd_st(ent_st_raw), .rd_sh(ent_sh),
    .we(t_we), .wr_addr(cur_addr), .wr_st(t_st), .wr_sh(t_sh));

  coh_dir_mem #(.NBLK(NBLK), .DATA_W(DATA_W)) mem_i (
    .clk(clk), .rst_n(rst_ni), .rd_addr(cur_addr), .rd_data(mem_rd),
    .we(d_we), .wr_addr(cur_addr), .wr_data(d_wdata));

  coh_dir_pick #(.N(NPROC)) own_pick_i (.vec(ent_sh), .idx(owner));
  coh_dir_pick #(.N(NPROC)) inv_pick_i (.vec(mask_q), .idx(inv_idx));

  // next-state and message selection
  always_comb begin
    fsm_d   = fsm_q;
    mask_d  = mask_q;
    t_we    = 1'b0;
    t_st    = ent_st;
    t_sh    = ent_sh;
    d_we    = 1'b0;
    d_wdata = req_data;
    m_v     = 1'b0;
    m_k     = MS_REPLY;
    m_dst   = cur_src;
    m_data  = mem_rd;
    unique case (fsm_q)
      FS_IDLE: if (accept) begin
        unique case (req_kind)
          RQ_READ: begin
            m_v = 1'b1;
            if (ent_st == ST_EXC) begin
              m_k = MS_FETCH; m_dst = owner; fsm_d = FS_WAIT;
            end else begin
              t_we = 1'b1; t_st = ST_SHR;
              t_sh = (ent_st == ST_SHR) ? (ent_sh | src_oh) : src_oh;
            end
          end
          RQ_WRITE: begin
            if (ent_st == ST_EXC && owner != req_src) begin
              m_v = 1'b1; m_k = MS_FINV; m_dst = owner; fsm_d = FS_WAIT;
            end else if (ent_st == ST_SHR && (ent_sh & ~src_oh) != '0) begin
              mask_d = ent_sh & ~src_oh; fsm_d = FS_INV;
            end else begin
              m_v = 1'b1; t_we = 1'b1; t_st = ST_EXC; t_sh = src_oh;
            end
          end
          RQ_WBACK: begin
            if (ent_st == ST_EXC && ent_sh == src_oh) begin
              d_we = 1'b1; t_we = 1'b1; t_st = ST_UNC; t_sh = '0;
            end
          end
          default: ;
        endcase
      end
      FS_INV: begin
        m_v = 1'b1;
        if (mask_q != '0) begin
          m_k    = MS_INVAL;
          m_dst  = inv_idx;
          mask_d = mask_q & ~({{(NPROC-1){1'b0}}, 1'b1} << inv_idx);
        end else begin
          t_we = 1'b1; t_st = ST_EXC; t_sh = src_oh; fsm_d = FS_IDLE;
        end
      end
      FS_WAIT: if (fet_valid) begin
        m_v    = 1'b1;
        m_data = fet_data;
        t_we   = 1'b1;
        fsm_d  = FS_IDLE;
        if (r_kind == RQ_READ) begin
          d_we = 1'b1; d_wdata = fet_data; t_st = ST_SHR; t_sh = ent_sh | src_oh;
        end else begin
          t_st = ST_EXC; t_sh = src_oh;
        end
      end
      default: fsm_d = FS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q     <= FS_IDLE;
      mask_q    <= '0;
      r_src     <= '0;
      r_addr    <= '0;
      r_kind    <= '0;
      msg_valid <= 1'b0;
      msg_kind  <= '0;
      msg_dst   <= '0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      fsm_q     <= fsm_d;
      mask_q    <= mask_d;
      msg_valid <= m_v;
      if (accept) begin
        r_src  <= req_src;
        r_addr <= req_addr;
        r_kind <= req_kind;
      end
      if (m_v) begin
        msg_kind <= m_k;
        msg_dst  <= m_dst;
        msg_addr <= cur_addr;
        msg_data <= m_data;
      end
    end
  end
endmodule

// File: rtl/coh_dir_home_chk.sv
module coh_dir_home_chk #(
  parameter int NPROC = 4,
  localparam int PID_W = $clog2(NPROC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_kind,
  input logic             msg_valid,
  input logic [1:0]       msg_kind,
  input logic [PID_W-1:0] msg_dst,
  input logic [PID_W-1:0] r_src
);
  // R5: an invalidate never targets the processor being served
  a_r5_inval_skips_req: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 2'd1) |-> (msg_dst != r_src));

  // R5: back-to-back invalidates go out in ascending ID order
  a_r5_inval_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 2'd1 && $past(msg_valid && msg_kind == 2'd1))
      |-> (msg_dst > $past(msg_dst)));

  // R10: no invalidate or fetch while new requests are accepted
  a_r10_busy_on_side_msgs: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind != 2'd0) |-> !req_ready);

  // R2/R4/R6: an accepted read miss always yields a message next cycle
  a_r6_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'd0) |=> msg_valid);

  // R8: an accepted write-back is silent
  a_r8_wback_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'd2) |=> !msg_valid);
endmodule

bind coh_dir_home coh_dir_home_chk #(.NPROC(NPROC)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .msg_valid(msg_valid), .msg_kind(msg_kind),
  .msg_dst(msg_dst), .r_src(r_src));

// File: tb/coh_dir_home_tb_top.sv
module coh_dir_home_tb_top;
  localparam int NPROC = 4, NBLK = 16, DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, fet_valid, msg_valid;
  logic [1:0]    req_kind, msg_kind;
  logic [1:0]    req_src, msg_dst;
  logic [3:0]    req_addr, msg_addr;
  logic [DW-1:0] req_data, fet_data, msg_data;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  coh_dir_home #(.NPROC(NPROC), .NBLK(NBLK), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
    .fet_valid(fet_valid), .fet_data(fet_data), .msg_valid(msg_valid),
    .msg_kind(msg_kind), .msg_dst(msg_dst), .msg_addr(msg_addr), .msg_data(msg_data));

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic issue(logic [1:0] k, logic [1:0] s, logic [3:0] a, logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_src = s; req_addr = a; req_data = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic expect_msg(string rq, logic [1:0] k, logic [1:0] dst, logic [3:0] a, logic [DW-1:0] d);
    chk(rq, "msg_valid", 64'(msg_valid), 64'd1);
    chk(rq, "msg_kind", 64'(msg_kind), 64'(k));
    chk(rq, "msg_dst", 64'(msg_dst), 64'(dst));
    chk(rq, "msg_addr", 64'(msg_addr), 64'(a));
    if (k == 2'd0) chk(rq, "msg_data", 64'(msg_data), 64'(d));
  endtask

  task automatic expect_none(string rq);
    chk(rq, "no msg", 64'(msg_valid), 64'd0);
  endtask

  task automatic return_data(logic [DW-1:0] d);
    fet_valid = 1'b1; fet_data = d;
    step();
    fet_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "req_ready", 64'(req_ready), 64'd1);
    expect_none("R1");
  endtask

  task automatic t_uncached_read();
    issue(2'd0, 2'd1, 4'd3, '0);
    expect_msg("R2", 2'd0, 2'd1, 4'd3, 32'd0);   // memory zero after reset (R1)
  endtask

  task automatic t_shared_read();
    issue(2'd0, 2'd3, 4'd3, '0);
    expect_msg("R4", 2'd0, 2'd3, 4'd3, 32'd0);
    issue(2'd0, 2'd0, 4'd3, '0);
    expect_msg("R4", 2'd0, 2'd0, 4'd3, 32'd0);
  endtask

  task automatic t_shared_write();
    issue(2'd1, 2'd1, 4'd3, '0);                 // sharers {0,1,3}
    expect_none("R5");
    chk("R10", "ready low", 64'(req_ready), 64'd0);
    step(); expect_msg("R5", 2'd1, 2'd0, 4'd3, '0);
    step(); expect_msg("R5", 2'd1, 2'd3, 4'd3, '0);
    step(); expect_msg("R5", 2'd0, 2'd1, 4'd3, 32'd0);
    chk("R10", "ready back", 64'(req_ready), 64'd1);
  endtask

  task automatic t_excl_read();
    issue(2'd0, 2'd2, 4'd3, '0);                 // owner 1
    expect_msg("R6", 2'd2, 2'd1, 4'd3, '0);
    chk("R10", "ready low", 64'(req_ready), 64'd0);
    step(); expect_none("R6");
    chk("R10", "stalled", 64'(req_ready), 64'd0);
    return_data(32'hABCD);
    expect_msg("R6", 2'd0, 2'd2, 4'd3, 32'hABCD);
    issue(2'd0, 2'd0, 4'd3, '0);                 // memory updated, state Shared
    expect_msg("R6", 2'd0, 2'd0, 4'd3, 32'hABCD);
  endtask

  task automatic t_stale_wback();
    issue(2'd2, 2'd2, 4'd3, 32'h5555);           // block Shared: ignored
    expect_none("R9");
    issue(2'd1, 2'd3, 4'd3, '0);                 // sharers still {0,1,2}
    expect_none("R9");
    step(); expect_msg("R9", 2'd1, 2'd0, 4'd3, '0);
    step(); expect_msg("R9", 2'd1, 2'd1, 4'd3, '0);
    step(); expect_msg("R9", 2'd1, 2'd2, 4'd3, '0);
    step(); expect_msg("R5", 2'd0, 2'd3, 4'd3, 32'hABCD);
  endtask

  task automatic t_excl_write();
    issue(2'd1, 2'd0, 4'd3, '0);                 // owner 3
    expect_msg("R7", 2'd3, 2'd3, 4'd3, '0);
    return_data(32'h1234);
    expect_msg("R7", 2'd0, 2'd0, 4'd3, 32'h1234);
    issue(2'd2, 2'd2, 4'd3, 32'h5555);           // non-owner write-back
    expect_none("R9");
    issue(2'd2, 2'd0, 4'd3, 32'h7777);           // owner write-back
    expect_none("R8");
    issue(2'd0, 2'd1, 4'd3, '0);                 // Uncached: reply from memory
    expect_msg("R8", 2'd0, 2'd1, 4'd3, 32'h7777);
  endtask

  task automatic t_uncached_write();
    issue(2'd1, 2'd2, 4'd9, '0);
    expect_msg("R3", 2'd0, 2'd2, 4'd9, 32'd0);
    chk("R3", "ready", 64'(req_ready), 64'd1);
    issue(2'd0, 2'd0, 4'd9, '0);                 // owner must be 2
    expect_msg("R3", 2'd2, 2'd2, 4'd9, '0);
    return_data(32'h42);
    expect_msg("R6", 2'd0, 2'd0, 4'd9, 32'h42);
  endtask

  task automatic t_sole_sharer_write();
    issue(2'd0, 2'd1, 4'd5, '0);
    expect_msg("R2", 2'd0, 2'd1, 4'd5, 32'd0);
    issue(2'd1, 2'd1, 4'd5, '0);                 // only sharer: immediate reply
    expect_msg("R5", 2'd0, 2'd1, 4'd5, 32'd0);
    issue(2'd0, 2'd2, 4'd5, '0);
    expect_msg("R5", 2'd2, 2'd1, 4'd5, '0);
    return_data(32'h99);
    expect_msg("R6", 2'd0, 2'd2, 4'd5, 32'h99);
    issue(2'd3, 2'd0, 4'd5, 32'h1);              // reserved kind: ignored
    expect_none("R9");
    issue(2'd0, 2'd3, 4'd5, '0);
    expect_msg("R9", 2'd0, 2'd3, 4'd5, 32'h99);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_src = '0; req_addr = '0;
    req_data = '0; fet_valid = 1'b0; fet_data = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_uncached_read();
    t_shared_read();
    t_shared_write();
    t_excl_read();
    t_stale_wback();
    t_excl_write();
    t_uncached_write();
    t_sole_sharer_write();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule